// File: doc/BRIEF.md
# Inbound PCI Address Window Translator

This block sits at the target side of a PCI bridge and examines the address phase of every transaction that an external PCI master aims at the device. It compares the address against three inbound windows and forms the address that the local bus will use. One window is fixed at 128 KB and always maps onto the device's internal register space: the upper address bits are replaced with the internal-space base, so a PCI master can reach the bridge's own registers without spending a programmable window. The other two windows are programmable, each with its own enable, PCI base, power-of-two size and local translation base.

For each strobed address the block reports one of two outcomes. It may report a hit, with a target class and the translated local address. It may report a miss, which tells the bus interface not to claim the transaction. Inside the fixed window, one range of offsets belongs to the bridge's register logic and every other offset goes on to the general internal register logic. The result is registered and appears one clock after the strobe. Handshaking and data movement are handled elsewhere.

Top module: `pci_inbound_xlate`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `res_valid`, `res_hit` and `res_miss` are 0, `res_class` is 0 and `res_addr` is 0.
- R2: A result for the address presented with `pci_valid` high appears on the outputs exactly one clock later, with `res_valid` high. Back-to-back strobes yield back-to-back results in order.
- R3: The dedicated window covers a 128 KB-aligned region. It hits when `pci_addr[31:17]` equals `regwin_base[31:17]`, and the translated address is `{int_base[31:17], pci_addr[16:0]}`.
- R4: Within a dedicated-window hit, an offset `pci_addr[16:0]` from 0x10400 to 0x10BFF inclusive gives class 1 (bridge register). Any other offset gives class 2 (internal register).
- R5: Translation window i of size 2^n bytes hits when `xwin_en[i]` is 1 and the address bits at and above bit n equal those of `xwin_base[i]`. The result is class 3 (local memory), with `xwin_xlat[i]` bits at and above n joined to the address bits below n.
- R6: The size field `xwin_size[i]` gives n. Values below 12 act as 12 (4 KB), and a value of 31 gives a 2 GB window.
- R7: A translation window whose enable bit is 0 never hits, and the other windows decode unchanged.
- R8: When windows overlap, the dedicated window wins over window 0, and window 0 wins over window 1.
- R9: A strobed address that hits no window gives `res_miss`=1, `res_hit`=0, class 0 and address 0.
- R10: In a cycle whose result slot carries no strobe (`res_valid`=0), `res_hit`, `res_miss` and `res_class` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_valid | input | 1 | Address-phase strobe |
| pci_addr | input | 32 | PCI address being decoded |
| regwin_base | input | 32 | PCI base of the dedicated 128 KB window (upper 15 bits used) |
| int_base | input | 32 | Local base of the internal register space (upper 15 bits used) |
| xwin_en | input | 2 | Enable per translation window |
| xwin_base | input | 2x32 | PCI base per translation window |
| xwin_size | input | 2x5 | Log2 of the byte size per translation window |
| xwin_xlat | input | 2x32 | Local translation base per translation window |
| res_valid | output | 1 | Result slot holds a decoded strobe |
| res_hit | output | 1 | Some window claimed the address |
| res_miss | output | 1 | No window claimed the address |
| res_class | output | 2 | 0 none, 1 bridge register, 2 internal register, 3 local memory |
| res_addr | output | 32 | Translated local address |

## Verification
The decoder is driven with addresses at both edges of the bridge-register offset range and one step outside them, which separates class 1 from class 2. Addresses are placed at the first and last byte of each translation window and one byte past the end, which exposes mistakes in mask width and offset merging. Overlapping configurations, in which the dedicated window lies inside both translation windows and window 0 lies inside window 1, show whether the priority order is right. Cleared enable bits and size codes below the minimum or at the top of the range check the gating and the clamping of the size field.

// File: rtl/pib_pkg.sv
package pib_pkg;
   typedef enum logic [1:0] {
      TGT_NONE   = 2'd0,
      TGT_BRIDGE = 2'd1,
      TGT_INTREG = 2'd2,
      TGT_LOCAL  = 2'd3
   } tgt_class_e;
endpackage

// File: rtl/pib_regwin_dec.sv
module pib_regwin_dec #(
   parameter int ADDR_W    = 32,
   parameter int WIN_LOG2  = 17,
   parameter int BRG_LO    = 'h10400,
   parameter int BRG_HI    = 'h10BFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] win_base,
   input  logic [ADDR_W-1:0] int_base,
   output logic              hit,
   output logic              is_bridge,
   output logic [ADDR_W-1:0] xaddr
);
   localparam logic [WIN_LOG2-1:0] LO_OFF = WIN_LOG2'(BRG_LO);
   localparam logic [WIN_LOG2-1:0] HI_OFF = WIN_LOG2'(BRG_HI);

   logic [WIN_LOG2-1:0] offset;

   always_comb begin
      offset    = addr[WIN_LOG2-1:0];
      hit       = (addr[ADDR_W-1:WIN_LOG2] == win_base[ADDR_W-1:WIN_LOG2]);
      is_bridge = (offset >= LO_OFF) && (offset <= HI_OFF);
      xaddr     = {int_base[ADDR_W-1:WIN_LOG2], offset};
   end
endmodule

// File: rtl/pib_xwin_dec.sv
module pib_xwin_dec #(
   parameter int ADDR_W   = 32,
   parameter int SZ_W     = 5,
   parameter int MIN_LOG2 = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_log2,
   input  logic [ADDR_W-1:0] xlat,
   output logic              hit,
   output logic [ADDR_W-1:0] xaddr
);
   logic [ADDR_W-1:0] low_mask;
   int unsigned       eff_log2;

   always_comb begin
      eff_log2 = (int'(size_log2) < MIN_LOG2) ? MIN_LOG2 : int'(size_log2);
      low_mask = '0;
      for (int b = 0; b < ADDR_W; b++) begin
         if (b < int'(eff_log2)) low_mask[b] = 1'b1;
      end
      hit   = en && (((addr ^ base) & ~low_mask) == '0);
      xaddr = (xlat & ~low_mask) | (addr & low_mask);
   end
endmodule

// File: rtl/pci_inbound_xlate.sv
module pci_inbound_xlate
   import pib_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_XWIN = 2,
   parameter int SZ_W     = 5,
   parameter int MIN_LOG2 = 12,
   parameter int WIN_LOG2 = 17,
   parameter int BRG_LO   = 'h10400,
   parameter int BRG_HI   = 'h10BFF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             pci_valid,
   input  logic [ADDR_W-1:0]                pci_addr,
   input  logic [ADDR_W-1:0]                regwin_base,
   input  logic [ADDR_W-1:0]                int_base,
   input  logic [NUM_XWIN-1:0]              xwin_en,
   input  logic [NUM_XWIN-1:0][ADDR_W-1:0]  xwin_base,
   input  logic [NUM_XWIN-1:0][SZ_W-1:0]    xwin_size,
   input  logic [NUM_XWIN-1:0][ADDR_W-1:0]  xwin_xlat,
   output logic                             res_valid,
   output logic                             res_hit,
   output logic                             res_miss,
   output logic [1:0]                       res_class,
   output logic [ADDR_W-1:0]                res_addr
);
   localparam int WIN_BYTES = 1 << WIN_LOG2;

   // elaboration-time parameter checks
   if (WIN_LOG2 >= ADDR_W) begin : g_bad_win
      $error("WIN_LOG2 must be below ADDR_W");
   end
   if (BRG_LO > BRG_HI || BRG_HI >= WIN_BYTES) begin : g_bad_brg
      $error("bridge offset range must be ordered and inside the window");
   end
   if (MIN_LOG2 < 1 || MIN_LOG2 > ADDR_W) begin : g_bad_min
      $error("MIN_LOG2 out of range");
   end
   if (NUM_XWIN < 1) begin : g_bad_num
      $error("need at least one translation window");
   end

   logic                             rw_hit, rw_brg;
   logic [ADDR_W-1:0]                rw_addr;
   logic [NUM_XWIN-1:0]              xw_hit;
   logic [NUM_XWIN-1:0][ADDR_W-1:0]  xw_addr;

   pib_regwin_dec #(
      .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .BRG_LO(BRG_LO), .BRG_HI(BRG_HI)
   ) u_regwin (
      .addr(pci_addr), .win_base(regwin_base), .int_base(int_base),
      .hit(rw_hit), .is_bridge(rw_brg), .xaddr(rw_addr)
   );

   for (genvar gi = 0; gi < NUM_XWIN; gi++) begin : g_xwin
      pib_xwin_dec #(
         .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2)
      ) u_xwin (
         .addr(pci_addr), .en(xwin_en[gi]), .base(xwin_base[gi]),
         .size_log2(xwin_size[gi]), .xlat(xwin_xlat[gi]),
         .hit(xw_hit[gi]), .xaddr(xw_addr[gi])
      );
   end

   // fixed priority: dedicated window, then lowest-numbered translation window
   logic              sel_hit;
   tgt_class_e        sel_class;
   logic [ADDR_W-1:0] sel_addr;

   always_comb begin
      sel_hit   = 1'b0;
      sel_class = TGT_NONE;
      sel_addr  = '0;
      for (int i = NUM_XWIN-1; i >= 0; i--) begin
         if (xw_hit[i]) begin
            sel_hit   = 1'b1;
            sel_class = TGT_LOCAL;
            sel_addr  = xw_addr[i];
         end
      end
      if (rw_hit) begin
         sel_hit   = 1'b1;
         sel_class = rw_brg ? TGT_BRIDGE : TGT_INTREG;
         sel_addr  = rw_addr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_miss  <= 1'b0;
         res_class <= TGT_NONE;
         res_addr  <= '0;
      end else begin
         res_valid <= pci_valid;
         res_hit   <= pci_valid && sel_hit;
         res_miss  <= pci_valid && !sel_hit;
         res_class <= pci_valid ? sel_class : TGT_NONE;
         res_addr  <= (pci_valid && sel_hit) ? sel_addr : '0;
      end
   end
endmodule

// File: rtl/pci_inbound_xlate_chk.sv
module pci_inbound_xlate_chk
   import pib_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int NUM_XWIN = 2,
   parameter int SZ_W     = 5,
   parameter int WIN_LOG2 = 17,
   parameter int BRG_LO   = 'h10400,
   parameter int BRG_HI   = 'h10BFF
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             pci_valid,
   input logic [ADDR_W-1:0]                pci_addr,
   input logic [ADDR_W-1:0]                regwin_base,
   input logic [ADDR_W-1:0]                int_base,
   input logic [NUM_XWIN-1:0]              xwin_en,
   input logic                             res_valid,
   input logic                             res_hit,
   input logic                             res_miss,
   input logic [1:0]                       res_class,
   input logic [ADDR_W-1:0]                res_addr
);
   logic rw_match;
   assign rw_match = (pci_addr[ADDR_W-1:WIN_LOG2] == regwin_base[ADDR_W-1:WIN_LOG2]);

   p_lat_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pci_valid |=> res_valid);
   p_lat_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pci_valid |=> !res_valid);
   p_regwin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_valid && rw_match) |=> (res_hit && res_class != 2'(TGT_LOCAL)
         && res_addr[ADDR_W-1:WIN_LOG2] == $past(int_base[ADDR_W-1:WIN_LOG2])
         && res_addr[WIN_LOG2-1:0] == $past(pci_addr[WIN_LOG2-1:0])));
   p_bridge_rng_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_class == 2'(TGT_BRIDGE)) |->
         (int'(res_addr[WIN_LOG2-1:0]) >= BRG_LO && int'(res_addr[WIN_LOG2-1:0]) <= BRG_HI));
   p_local_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_class == 2'(TGT_LOCAL)) |-> res_hit);
   p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pci_valid && xwin_en == '0 && !rw_match) |=> res_miss);
   p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> (!res_hit && res_class == 2'(TGT_NONE) && res_addr == '0));
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_miss && res_class == 2'(TGT_NONE)));
   p_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot({res_hit, res_miss}));
endmodule

bind pci_inbound_xlate pci_inbound_xlate_chk #(
   .ADDR_W(ADDR_W), .NUM_XWIN(NUM_XWIN), .SZ_W(SZ_W),
   .WIN_LOG2(WIN_LOG2), .BRG_LO(BRG_LO), .BRG_HI(BRG_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pci_valid(pci_valid), .pci_addr(pci_addr),
   .regwin_base(regwin_base), .int_base(int_base), .xwin_en(xwin_en),
   .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
   .res_class(res_class), .res_addr(res_addr)
);

// File: tb/pci_inbound_xlate_bench.sv
module pci_inbound_xlate_bench;
   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 pci_valid = 1'b0;
   logic [31:0]          pci_addr = '0;
   logic [31:0]          regwin_base = '0;
   logic [31:0]          int_base = '0;
   logic [1:0]           xwin_en = '0;
   logic [1:0][31:0]     xwin_base = '0;
   logic [1:0][4:0]      xwin_size = '0;
   logic [1:0][31:0]     xwin_xlat = '0;
   logic                 res_valid, res_hit, res_miss;
   logic [1:0]           res_class;
   logic [31:0]          res_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit mon_on = 1'b0;

   typedef struct packed {
      logic        hit;
      logic [1:0]  cls;
      logic [31:0] addr;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   pci_inbound_xlate u_pci_inbound_xlate (
      .clk(clk), .rst_n(rst_n), .pci_valid(pci_valid), .pci_addr(pci_addr),
      .regwin_base(regwin_base), .int_base(int_base), .xwin_en(xwin_en),
      .xwin_base(xwin_base), .xwin_size(xwin_size), .xwin_xlat(xwin_xlat),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
      .res_class(res_class), .res_addr(res_addr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // driver: present one address for one cycle and queue its expectation
   task automatic drive(input logic [31:0] a, input logic hit,
                        input logic [1:0] cls, input logic [31:0] xa, input string tag);
      exp_t e;
      @(negedge clk);
      pci_valid = 1'b1;
      pci_addr  = a;
      e.hit = hit; e.cls = hit ? cls : 2'd0; e.addr = hit ? xa : 32'd0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         pci_valid = 1'b0;
         pci_addr  = 32'hDEAD_BEEF;
      end
   endtask

   // monitor: compare each result slot against the scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (res_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected result", 64'(res_valid), 64'd0);
            end else begin
               exp_t  e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(res_hit == e.hit && res_miss == !e.hit && res_class == e.cls
                   && res_addr == e.addr, t, "hit/miss/class/addr",
                   {29'd0, res_hit, res_class, res_addr},
                   {29'd0, e.hit, e.cls, e.addr});
            end
         end else begin
            chk(!res_hit && !res_miss && res_class == 2'd0, "R10", "idle slot flags",
                {61'd0, res_hit, res_miss, res_class[0]}, 64'd0);
         end
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!res_valid && !res_hit && !res_miss && res_class == 0 && res_addr == 0,
          "R1", "outputs in reset", {res_valid, res_hit, res_miss, res_class, res_addr}, 64'd0);
      regwin_base  = 32'h8000_0000;
      int_base     = 32'hF000_0000;
      xwin_en      = 2'b11;
      xwin_base[0] = 32'h4000_0000; xwin_size[0] = 5'd20; xwin_xlat[0] = 32'h0010_0000;
      xwin_base[1] = 32'h4000_0000; xwin_size[1] = 5'd24; xwin_xlat[1] = 32'h0200_0000;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!res_valid && !res_hit && !res_miss && res_class == 0 && res_addr == 0,
          "R1", "outputs after release", {res_valid, res_hit, res_miss, res_class, res_addr}, 64'd0);
      mon_on = 1'b1;

      // dedicated window, bridge offset range edges (R4), back-to-back (R2)
      drive(32'h8001_0400, 1, 2'd1, 32'hF001_0400, "R4");
      drive(32'h8001_0BFF, 1, 2'd1, 32'hF001_0BFF, "R4");
      drive(32'h8001_03FF, 1, 2'd2, 32'hF001_03FF, "R4");
      drive(32'h8001_0C00, 1, 2'd2, 32'hF001_0C00, "R2");
      drive(32'h8000_0000, 1, 2'd2, 32'hF000_0000, "R3");
      drive(32'h8001_FFFF, 1, 2'd2, 32'hF001_FFFF, "R3");
      drive(32'h8002_0000, 0, 2'd0, 32'h0, "R9");
      idle(2);
      // translation windows, window 0 inside window 1 (R5, R8)
      drive(32'h4000_1234, 1, 2'd3, 32'h0010_1234, "R8");
      drive(32'h400F_FFFF, 1, 2'd3, 32'h001F_FFFF, "R5");
      drive(32'h4010_0000, 1, 2'd3, 32'h0210_0000, "R5");
      drive(32'h40FF_FFFC, 1, 2'd3, 32'h02FF_FFFC, "R5");
      drive(32'h4100_0000, 0, 2'd0, 32'h0, "R9");
      idle(3);

      // dedicated window placed inside both translation windows (R8)
      regwin_base = 32'h4000_0000;
      drive(32'h4000_1234, 1, 2'd2, 32'hF000_1234, "R8");
      drive(32'h4001_0500, 1, 2'd1, 32'hF001_0500, "R8");
      drive(32'h4002_0000, 1, 2'd3, 32'h0012_0000, "R8");
      idle(3);

      // enable gating (R7)
      regwin_base = 32'h8000_0000;
      xwin_en = 2'b10;
      drive(32'h4000_1234, 1, 2'd3, 32'h0200_1234, "R7");
      idle(3);
      xwin_en = 2'b00;
      drive(32'h4000_1234, 0, 2'd0, 32'h0, "R7");
      drive(32'h8000_0010, 1, 2'd2, 32'hF000_0010, "R7");
      idle(3);

      // size clamping (R6)
      xwin_en = 2'b01;
      xwin_base[0] = 32'h5000_0000; xwin_size[0] = 5'd3; xwin_xlat[0] = 32'h0000_A000;
      drive(32'h5000_0FFF, 1, 2'd3, 32'h0000_AFFF, "R6");
      drive(32'h5000_1000, 0, 2'd0, 32'h0, "R6");
      idle(3);
      xwin_base[0] = 32'h0000_0000; xwin_size[0] = 5'd31; xwin_xlat[0] = 32'h8000_0000;
      drive(32'h1234_5678, 1, 2'd3, 32'h9234_5678, "R6");
      idle(4);

      chk(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) chk(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule